// File: doc/BRIEF.md
# Voice Routing Into Filter

This block sits in front of a state-variable audio filter. It takes three voice samples and one external sample, scales each from the wide source format down to the filter's working width, and splits them between two sums. One sum feeds the filter. The other is a bypass sum that skips the filter. A four-bit route mask picks the path for each source.

A mute flag silences voice three, but only on the bypass path. If voice three is routed into the filter, the flag has no effect on it. A filter-enable input of zero sends every source to the bypass sum and forces the filter sum to zero.

Both sums are registered once per sample strobe. The mask and the control flags are sampled on the same strobe as the data.

Top module: `vroute_top`

## Requirements
- R1: While reset is asserted, and after its release until the first strobe, both `filt_sum` and `bypass_sum` read zero.
- R2: Each 20-bit two's-complement source is reduced to 13 bits by an arithmetic right shift of 7, which rounds toward minus infinity. For example, -1 gives -1, -128 gives -1, 127 gives 0 and 128 gives 1.
- R3: The bits of `route_mask` select the sources: bit 0 is voice 1, bit 1 is voice 2, bit 2 is voice 3 and bit 3 is the external input. When `filt_en` is 1, a set bit adds that scaled source to `filt_sum` and a clear bit adds it to `bypass_sum`.
- R4: When `v3_mute` is 1 and mask bit 2 is 0, voice 3 contributes zero to both sums.
- R5: When `v3_mute` is 1 and mask bit 2 is 1, voice 3 still enters `filt_sum` with its full scaled value.
- R6: When `filt_en` is 0:
  - `filt_sum` is zero.
  - `bypass_sum` is the sum of all four scaled sources, whatever the mask.
  - The mute rule of R4 still depends on mask bit 2.
- R7: The outputs change only on a rising clock edge where `strobe` is 1. On every other edge they hold their value, and the inputs are ignored.
- R8: Each sum is 15 bits signed and never overflows. Four sources at +4095 give +16380, and four at -4096 give -16384.
- R9: With `filt_en` at 1, a mask of 0 gives `filt_sum` = 0, and a mask of 4'hF gives `bypass_sum` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strobe | input | 1 | Sample strobe: capture on this edge |
| voice1 | input | 20 | Voice 1 sample, signed |
| voice2 | input | 20 | Voice 2 sample, signed |
| voice3 | input | 20 | Voice 3 sample, signed |
| ext_in | input | 20 | External input sample, signed |
| route_mask | input | 4 | Per-source path select, 1 = into filter |
| v3_mute | input | 1 | Silences voice 3 when it is not routed to the filter |
| filt_en | input | 1 | 0 sends every source to the bypass sum |
| filt_sum | output | 15 | Registered filter-input sum, signed |
| bypass_sum | output | 15 | Registered bypass sum, signed |

## Verification
The assertions check four things on every cycle:
- the outputs hold between strobes;
- `filt_sum` is zero whenever the filter is disabled, and zero for an empty mask;
- `bypass_sum` is zero for a full mask;
- when voice 3 is not muted, the two sums together equal the total of the scaled inputs.

Only the bench's sweep can show two other things. One is that each individual mask bit steers the right source. The other is the asymmetric voice-3 mute and how it interacts with the disable input. The bench also covers the rounding of negative values and the extreme totals.

// File: rtl/vroute_pkg.sv
package vroute_pkg;
    // Number of routed sources and the position of the mutable voice.
    localparam int NSRC   = 4;
    localparam int V3_IDX = 2;
endpackage

// File: rtl/vroute_scaler.sv
module vroute_scaler #(
    parameter int IN_W  = 20,
    parameter int SHIFT = 7,
    localparam int SC_W = IN_W - SHIFT
) (
    input  logic signed [IN_W-1:0] din,
    output logic signed [SC_W-1:0] dout
);
    // Keeping the top bits is an arithmetic shift with the result truncated.
    logic unused_low;
    assign unused_low = ^din[SHIFT-1:0];
    assign dout       = din[IN_W-1:SHIFT];
endmodule

// File: rtl/vroute_splitter.sv
module vroute_splitter
    import vroute_pkg::*;
#(
    parameter int SC_W  = 13,
    parameter int SUM_W = 15
) (
    input  logic signed [SC_W-1:0]  src [NSRC],
    input  logic [NSRC-1:0]         mask,
    input  logic                    mute,
    input  logic                    en,
    output logic signed [SUM_W-1:0] fsum,
    output logic signed [SUM_W-1:0] bsum
);
    logic signed [SUM_W-1:0] term  [NSRC];
    logic [NSRC-1:0]         to_flt;

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        if (i == V3_IDX) begin : g_mutable
            // Mute affects only the bypass path.
            assign term[i] = (mute && !mask[i]) ? '0
                           : {{(SUM_W-SC_W){src[i][SC_W-1]}}, src[i]};
        end else begin : g_plain
            assign term[i] = {{(SUM_W-SC_W){src[i][SC_W-1]}}, src[i]};
        end
        assign to_flt[i] = en && mask[i];
    end

    always_comb begin
        fsum = '0;
        bsum = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (to_flt[i]) fsum = fsum + term[i];
            else           bsum = bsum + term[i];
        end
    end
endmodule

// File: rtl/vroute_top.sv
module vroute_top
    import vroute_pkg::*;
#(
    parameter int IN_W   = 20,
    parameter int SHIFT  = 7,
    localparam int SC_W  = IN_W - SHIFT,
    localparam int SUM_W = SC_W + $clog2(NSRC)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    strobe,
    input  logic signed [IN_W-1:0]  voice1,
    input  logic signed [IN_W-1:0]  voice2,
    input  logic signed [IN_W-1:0]  voice3,
    input  logic signed [IN_W-1:0]  ext_in,
    input  logic [NSRC-1:0]         route_mask,
    input  logic                    v3_mute,
    input  logic                    filt_en,
    output logic signed [SUM_W-1:0] filt_sum,
    output logic signed [SUM_W-1:0] bypass_sum
);
    logic signed [IN_W-1:0]  raw    [NSRC];
    logic signed [SC_W-1:0]  scaled [NSRC];
    logic signed [SUM_W-1:0] f_nxt, b_nxt;

    assign raw[0] = voice1;
    assign raw[1] = voice2;
    assign raw[2] = voice3;
    assign raw[3] = ext_in;

    for (genvar i = 0; i < NSRC; i++) begin : g_scale
        vroute_scaler #(.IN_W(IN_W), .SHIFT(SHIFT)) u_scl (
            .din  (raw[i]),
            .dout (scaled[i])
        );
    end

    vroute_splitter #(.SC_W(SC_W), .SUM_W(SUM_W)) u_split (
        .src  (scaled),
        .mask (route_mask),
        .mute (v3_mute),
        .en   (filt_en),
        .fsum (f_nxt),
        .bsum (b_nxt)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            filt_sum   <= '0;
            bypass_sum <= '0;
        end else if (strobe) begin
            filt_sum   <= f_nxt;
            bypass_sum <= b_nxt;
        end
    end
endmodule

// File: rtl/vroute_chk.sv
module vroute_chk #(
    parameter int IN_W  = 20,
    parameter int SHIFT = 7,
    parameter int SUM_W = 15
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    strobe,
    input logic signed [IN_W-1:0]  voice1,
    input logic signed [IN_W-1:0]  voice2,
    input logic signed [IN_W-1:0]  voice3,
    input logic signed [IN_W-1:0]  ext_in,
    input logic [3:0]              route_mask,
    input logic                    v3_mute,
    input logic                    filt_en,
    input logic signed [SUM_W-1:0] filt_sum,
    input logic signed [SUM_W-1:0] bypass_sum
);
    function automatic logic signed [SUM_W:0] scl(input logic signed [IN_W-1:0] x);
        logic signed [IN_W-1:0] t;
        t = x >>> SHIFT;
        return (SUM_W+1)'(t);
    endfunction

    function automatic logic signed [SUM_W:0] wide(input logic signed [SUM_W-1:0] x);
        return (SUM_W+1)'(x);
    endfunction

    // R1: the outputs are zero while reset is held.
    always @(posedge clk) begin
        if (!rst_n) a_r1_reset_zero: assert (filt_sum == '0 && bypass_sum == '0);
    end

    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe |=> ($stable(filt_sum) && $stable(bypass_sum)));

    a_r6_disabled_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && rst_n && !filt_en) |=> (filt_sum == '0));

    a_r9_empty_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && rst_n && filt_en && route_mask == 4'h0) |=> (filt_sum == '0));

    a_r9_full_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && rst_n && filt_en && route_mask == 4'hF) |=> (bypass_sum == '0));

    a_r8_conserve: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && rst_n && !v3_mute) |=>
        (wide(filt_sum) + wide(bypass_sum) ==
         scl($past(voice1)) + scl($past(voice2)) + scl($past(voice3)) + scl($past(ext_in))));
endmodule

bind vroute_top vroute_chk #(.IN_W(IN_W), .SHIFT(SHIFT), .SUM_W(SUM_W)) u_chk (.*);

// File: tb/vroute_top_tb.sv
module vroute_top_tb;
    logic clk = 0;
    logic rst_n = 0;
    logic strobe = 0;
    logic signed [19:0] v [4];
    logic [3:0] mask = 0;
    logic mute = 0, en = 0;
    logic signed [14:0] fsum, bsum;
    int total = 0, bad = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    vroute_top u_dut (
        .clk(clk), .rst_n(rst_n), .strobe(strobe),
        .voice1(v[0]), .voice2(v[1]), .voice3(v[2]), .ext_in(v[3]),
        .route_mask(mask), .v3_mute(mute), .filt_en(en),
        .filt_sum(fsum), .bypass_sum(bsum)
    );

    // Scaling by floor division by 128, computed without a shift operator.
    function automatic int scale(input int x);
        int q;
        q = x / 128;
        if (x < 0 && q * 128 != x) q = q - 1;
        return q;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic apply(input int a, input int b, input int c, input int d,
                         input logic [3:0] m, input logic mu, input logic e);
        int s [4];
        int ef, eb;
        string tag;
        @(negedge clk);
        v[0] = 20'(a); v[1] = 20'(b); v[2] = 20'(c); v[3] = 20'(d);
        mask = m; mute = mu; en = e; strobe = 1;
        @(negedge clk);
        strobe = 0;
        s[0] = scale(a); s[1] = scale(b); s[2] = scale(c); s[3] = scale(d);
        if (mu && !m[2]) s[2] = 0;
        ef = 0; eb = 0;
        for (int i = 0; i < 4; i++) begin
            if (e && m[i]) ef += s[i];
            else           eb += s[i];
        end
        if (!e)                        tag = "R6";
        else if (m == 0 || m == 4'hF)  tag = "R9";
        else if (mu)                   tag = m[2] ? "R5" : "R4";
        else                           tag = "R3";
        check({tag, " filt"}, int'(fsum), ef);
        check({tag, " bypass"}, int'(bsum), eb);
    endtask

    initial begin
        int pat [5][4];
        for (int i = 0; i < 4; i++) v[i] = 0;
        pat[0] = '{1000, 2000, 3000, 4000};
        pat[1] = '{-1, -128, 127, 128};
        pat[2] = '{524287, 524287, 524287, 524287};
        pat[3] = '{-524288, -524288, -524288, -524288};
        pat[4] = '{-70000, 33333, -250000, 99999};
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 filt", int'(fsum), 0);
        check("R1 bypass", int'(bsum), 0);
        rst_n = 1;
        @(negedge clk);
        check("R1 after release", int'(fsum) + int'(bsum), 0);

        // R2: rounding of negative and boundary values.
        apply(-1, -128, 127, 128, 4'h0, 0, 1);
        check("R2 scale", int'(bsum), -1 - 1 + 0 + 1);

        // R8: extreme totals fit.
        apply(524287, 524287, 524287, 524287, 4'h0, 0, 1);
        check("R8 max", int'(bsum), 16380);
        apply(-524288, -524288, -524288, -524288, 4'hF, 0, 1);
        check("R8 min", int'(fsum), -16384);

        // Sweep every pattern, mask, mute and enable value.
        for (int p = 0; p < 5; p++)
            for (int m = 0; m < 16; m++)
                for (int mu = 0; mu < 2; mu++)
                    for (int e = 0; e < 2; e++)
                        apply(pat[p][0], pat[p][1], pat[p][2], pat[p][3],
                              4'(m), 1'(mu), 1'(e));

        // R7: inputs change without a strobe; the outputs must hold.
        apply(1000, 2000, 3000, 4000, 4'h5, 0, 1);
        @(negedge clk);
        v[0] = 20'(-300000); v[1] = 20'(77777); mask = 4'hA; en = 0; mute = 1;
        repeat (3) @(negedge clk);
        check("R7 hold filt", int'(fsum), 7 + 23);
        check("R7 hold bypass", int'(bsum), 15 + 31);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule